// File: doc/BRIEF.md
# Serial EEPROM Transaction Controller

This block sits between a two-wire bus target engine and the storage of an 8192-byte non-volatile array. The engine reports byte-level events: START (including repeated START), STOP, each received byte, and the master's acknowledge after each byte the target sends. The controller turns these events into memory operations. It decodes the device header and loads a 13-bit word address from two address bytes. It decides the acknowledge for every received byte. It forwards write data to a page buffer, which is committed on STOP, and fetches read data from a synchronous read port.

Supported operations are byte write, page write inside a 32-byte page, current-address read, random read, and sequential read. A random read is a header with the write direction, two address bytes, a repeated START, and a header with the read direction. A hardware protect input makes the top quarter of the array read-only. It does this by refusing the first data byte.

The state machine uses nine states:

- `ST_IDLE`
- `ST_HDR`
- `ST_ADDR_HI`
- `ST_ADDR_LO`
- `ST_WDATA`
- `ST_RD_ISSUE`
- `ST_RD_CAPT`
- `ST_RD_SEND`
- `ST_WAIT_STOP`

STOP moves any state to `ST_IDLE`. START moves any state to `ST_HDR`. The header leads to one of three places:

- a mismatched header returns to `ST_IDLE`;
- a matching write header goes to `ST_ADDR_HI`;
- a matching read header goes to `ST_RD_ISSUE`.

The write path is `ST_ADDR_HI` → `ST_ADDR_LO` → `ST_WDATA`. A refused protected byte moves `ST_WDATA` to `ST_WAIT_STOP`.

The read path is `ST_RD_ISSUE` → `ST_RD_CAPT` → `ST_RD_SEND`. In `ST_RD_SEND`, a master acknowledge returns to `ST_RD_ISSUE` and a missing acknowledge goes to `ST_WAIT_STOP`.

Top module: `eeprom_txn_ctrl`

## Requirements
- R1: A received header matches when bits [7:4] are 4'b1010 and bits [3:1] equal `dev_sel`; bit 0 is 1 for read and 0 for write. `ack_valid` pulses one cycle after `rx_valid` with `ack`=1 for a match and `ack`=0 otherwise. After a mismatch, received bytes draw no `ack_valid` until the next START.
- R2: After a matching write header, the next two bytes are acknowledged and form the word address, high byte first. Only bits [4:0] of the high byte are used; its upper three bits are ignored.
- R3: In the data phase, each writable byte is acknowledged and presented on `pb_wr_en`/`pb_addr`/`pb_data` one cycle after `rx_valid`. A STOP that follows at least one such byte pulses `pb_commit` once, one cycle after `ev_stop`.
- R4: Page write: after each written byte the pointer's low 5 bits increment and wrap within the 32-byte page; the upper 8 bits stay fixed.
- R5: A current-address read returns the byte at the pointer, which holds the last accessed address plus one.
- R6: Random read: after the two address bytes, a repeated START with a read header returns first the byte at the loaded address.
- R7: Sequential read: each master acknowledge or non-acknowledge advances the full 13-bit pointer by one, wrapping from 8191 to 0; an acknowledge starts the fetch of the next byte.
- R8: With `wp`=1, a data byte aimed at 0x1800–0x1FFF gets `ack`=0, and there is no page buffer write and no commit. The header and both address bytes are still acknowledged.
- R9: With `wp`=0 the whole array is writable, and with `wp`=1 addresses below 0x1800 stay writable.
- R10: A STOP before both address bytes are received starts no write and leaves the pointer unchanged.
- R11: After a read ended by a missing master acknowledge, received bytes draw no `ack_valid` until STOP.
- R12: A read fetch is issued as a one-cycle `mem_rd_en` pulse before the engine needs the byte. `tx_valid` rises two cycles after that pulse and holds `tx_data` until the master's response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_sel | input | 3 | Strapped device select compared with header bits [3:1] |
| wp | input | 1 | Protect enable for the top quarter of the array |
| ev_start | input | 1 | One-cycle pulse: START or repeated START seen |
| ev_stop | input | 1 | One-cycle pulse: STOP seen |
| rx_valid | input | 1 | One-cycle pulse: a byte was received from the master |
| rx_byte | input | 8 | Received byte, valid with `rx_valid` |
| ack_valid | output | 1 | Acknowledge decision valid |
| ack | output | 1 | 1 = acknowledge the received byte |
| mack_valid | input | 1 | One-cycle pulse: master response to a sent byte |
| mack | input | 1 | 1 = master acknowledged |
| tx_valid | output | 1 | Byte to send is ready |
| tx_data | output | 8 | Byte to send |
| pb_wr_en | output | 1 | Page buffer write strobe |
| pb_addr | output | 13 | Page buffer target address |
| pb_data | output | 8 | Page buffer data |
| pb_commit | output | 1 | Commit the page buffer to the array |
| mem_rd_en | output | 1 | Synchronous read request |
| mem_rd_addr | output | 13 | Read address |
| mem_rd_data | input | 8 | Read data, one cycle after `mem_rd_en` |

## Verification
Two functions can fall in the same cycle: the pointer update and the read fetch that depends on it.

In one case, a master acknowledge advances the pointer in the cycle just before the next fetch is issued, and the fetch must already see the advanced value. The bench provokes this with sequential reads that run across address 8191. It judges every returned byte against a reference copy of the array, so the bytes at 0 and 1 must follow those at 8190 and 8191.

In the other case, the low address byte loads the pointer only cycles before a repeated START and read header launch the fetch. The random reads drive these events back to back, and the first returned byte must come from the newly loaded address.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

    localparam logic [3:0] DEV_ID = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HDR,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_WDATA,
        ST_RD_ISSUE,
        ST_RD_CAPT,
        ST_RD_SEND,
        ST_WAIT_STOP
    } txn_state_t;

endpackage

// File: rtl/eeprom_hdr_decode.sv
module eeprom_hdr_decode #(
    parameter int DEV_W = 3
) (
    input  logic [7:0]       hdr_byte,
    input  logic [DEV_W-1:0] dev_sel,
    output logic             hdr_match,
    output logic             hdr_read
);
    import eeprom_pkg::*;

    localparam int ID_W = 7 - DEV_W;

    // Family code in the top bits, strapped select below it, direction in bit 0.
    assign hdr_match = (hdr_byte[7 -: ID_W] == DEV_ID[3 -: ID_W]) &&
                       (hdr_byte[DEV_W:1] == dev_sel);
    assign hdr_read  = hdr_byte[0];

endmodule

// File: rtl/eeprom_wp_guard.sv
module eeprom_wp_guard #(
    parameter int ADDR_W = 13
) (
    input  logic              wp,
    input  logic [ADDR_W-1:0] addr,
    output logic              locked
);
    // Top quarter: both address MSBs set.
    assign locked = wp && (addr[ADDR_W-1 -: 2] == 2'b11);

endmodule

// File: rtl/eeprom_ptr_next.sv
module eeprom_ptr_next #(
    parameter int ADDR_W = 13,
    parameter int PAGE_W = 5
) (
    input  logic [ADDR_W-1:0] ptr,
    output logic [ADDR_W-1:0] page_next,
    output logic [ADDR_W-1:0] lin_next
);
    localparam int ROW_W = ADDR_W - PAGE_W;

    logic [PAGE_W-1:0] col_inc;

    assign col_inc   = ptr[PAGE_W-1:0] + PAGE_W'(1);
    assign lin_next  = ptr + ADDR_W'(1);

    generate
        if (ROW_W > 0) begin : g_row
            assign page_next = {ptr[ADDR_W-1:PAGE_W], col_inc};
        end else begin : g_flat
            assign page_next = col_inc;
        end
    endgenerate

endmodule

// File: rtl/eeprom_txn_ctrl.sv
module eeprom_txn_ctrl #(
    parameter int ADDR_W = 13,
    parameter int PAGE_W = 5,
    parameter int DEV_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DEV_W-1:0]  dev_sel,
    input  logic              wp,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic              ack_valid,
    output logic              ack,
    input  logic              mack_valid,
    input  logic              mack,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              pb_wr_en,
    output logic [ADDR_W-1:0] pb_addr,
    output logic [7:0]        pb_data,
    output logic              pb_commit,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [7:0]        mem_rd_data
);
    import eeprom_pkg::*;

    localparam int HI_W = ADDR_W - 8;

    txn_state_t        state_q, state_d;
    logic [ADDR_W-1:0] ptr_q;
    logic [HI_W-1:0]   addr_hi_q;
    logic [7:0]        tx_q;
    logic              have_data_q;

    logic              hdr_match, hdr_read, locked;
    logic [ADDR_W-1:0] page_next, lin_next;

    eeprom_hdr_decode #(.DEV_W(DEV_W)) u_hdr (
        .hdr_byte (rx_byte),
        .dev_sel  (dev_sel),
        .hdr_match(hdr_match),
        .hdr_read (hdr_read)
    );

    eeprom_wp_guard #(.ADDR_W(ADDR_W)) u_wp (
        .wp    (wp),
        .addr  (ptr_q),
        .locked(locked)
    );

    eeprom_ptr_next #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
        .ptr      (ptr_q),
        .page_next(page_next),
        .lin_next (lin_next)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic: STOP wins, then START, then per-state events
    always_comb begin
        state_d = state_q;
        if (ev_stop) begin
            state_d = ST_IDLE;
        end else if (ev_start) begin
            state_d = ST_HDR;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_HDR:       if (rx_valid) state_d = !hdr_match ? ST_IDLE :
                                                      (hdr_read ? ST_RD_ISSUE : ST_ADDR_HI);
                ST_ADDR_HI:   if (rx_valid) state_d = ST_ADDR_LO;
                ST_ADDR_LO:   if (rx_valid) state_d = ST_WDATA;
                ST_WDATA:     if (rx_valid && locked) state_d = ST_WAIT_STOP;
                ST_RD_ISSUE:  state_d = ST_RD_CAPT;
                ST_RD_CAPT:   state_d = ST_RD_SEND;
                ST_RD_SEND:   if (mack_valid) state_d = mack ? ST_RD_ISSUE : ST_WAIT_STOP;
                ST_WAIT_STOP: state_d = ST_WAIT_STOP;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_valid   <= 1'b0;
            ack         <= 1'b0;
            pb_wr_en    <= 1'b0;
            pb_addr     <= '0;
            pb_data     <= '0;
            pb_commit   <= 1'b0;
            ptr_q       <= '0;
            addr_hi_q   <= '0;
            tx_q        <= '0;
            have_data_q <= 1'b0;
        end else begin
            ack_valid <= 1'b0;
            pb_wr_en  <= 1'b0;
            pb_commit <= 1'b0;
            if (ev_stop) begin
                pb_commit   <= (state_q == ST_WDATA) && have_data_q;
                have_data_q <= 1'b0;
            end else if (ev_start) begin
                have_data_q <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_HDR: if (rx_valid) begin
                        ack_valid <= 1'b1;
                        ack       <= hdr_match;
                    end
                    ST_ADDR_HI: if (rx_valid) begin
                        ack_valid <= 1'b1;
                        ack       <= 1'b1;
                        addr_hi_q <= rx_byte[HI_W-1:0];
                    end
                    ST_ADDR_LO: if (rx_valid) begin
                        ack_valid   <= 1'b1;
                        ack         <= 1'b1;
                        ptr_q       <= {addr_hi_q, rx_byte};
                        have_data_q <= 1'b0;
                    end
                    ST_WDATA: if (rx_valid) begin
                        ack_valid <= 1'b1;
                        ack       <= !locked;
                        if (!locked) begin
                            pb_wr_en    <= 1'b1;
                            pb_addr     <= ptr_q;
                            pb_data     <= rx_byte;
                            ptr_q       <= page_next;
                            have_data_q <= 1'b1;
                        end
                    end
                    ST_RD_CAPT: tx_q <= mem_rd_data;
                    ST_RD_SEND: if (mack_valid) ptr_q <= lin_next;
                    default: ;
                endcase
            end
        end
    end

    assign mem_rd_en   = (state_q == ST_RD_ISSUE);
    assign mem_rd_addr = ptr_q;
    assign tx_valid    = (state_q == ST_RD_SEND);
    assign tx_data     = tx_q;

    AST_ACK_AFTER_RX: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> $past(rx_valid)); // R1

    AST_COMMIT_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        pb_commit |-> $past(ev_stop)); // R3

    AST_WP_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        pb_wr_en |-> !($past(wp) && pb_addr[ADDR_W-1 -: 2] == 2'b11)); // R8

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && $past(mack_valid)) |-> mem_rd_addr == ADDR_W'($past(mem_rd_addr) + 1)); // R7

    AST_FETCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en); // R12

    AST_TX_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> $past(mem_rd_en, 2)); // R12

endmodule

// File: tb/test_eeprom_txn_ctrl.sv
module test_eeprom_txn_ctrl;

    localparam int          AW  = 13;
    localparam logic [2:0]  DEV = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] dev_sel = DEV;
    logic wp = 1'b0;
    logic ev_start = 1'b0, ev_stop = 1'b0, rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic ack_valid, ack;
    logic mack_valid = 1'b0, mack = 1'b0;
    logic tx_valid;
    logic [7:0] tx_data;
    logic pb_wr_en, pb_commit, mem_rd_en;
    logic [AW-1:0] pb_addr, mem_rd_addr;
    logic [7:0] pb_data;
    logic [7:0] mem_rd_data = '0;

    always #5 clk = ~clk;

    eeprom_txn_ctrl i_eeprom_txn_ctrl (
        .clk(clk), .rst_n(rst_n), .dev_sel(dev_sel), .wp(wp),
        .ev_start(ev_start), .ev_stop(ev_stop), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .ack_valid(ack_valid), .ack(ack), .mack_valid(mack_valid), .mack(mack),
        .tx_valid(tx_valid), .tx_data(tx_data),
        .pb_wr_en(pb_wr_en), .pb_addr(pb_addr), .pb_data(pb_data), .pb_commit(pb_commit),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data)
    );

    // Array behind the page buffer and the read port, plus an independent reference copy
    logic [7:0] arr [8192];
    logic [7:0] ref_mem [8192];
    int         ref_ptr;
    logic [AW-1:0] stg_a [$];
    logic [7:0]    stg_d [$];

    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= arr[mem_rd_addr];
        if (pb_wr_en) begin
            stg_a.push_back(pb_addr);
            stg_d.push_back(pb_data);
        end
        if (pb_commit) begin
            foreach (stg_a[k]) arr[stg_a[k]] = stg_d[k];
            stg_a.delete();
            stg_d.delete();
        end
    end

    typedef struct {
        bit         is_tx;
        logic [7:0] val;
        string      tag;
    } exp_t;

    exp_t q[$];
    int compared = 0;
    int mismatched = 0;
    logic tx_prev = 1'b0;
    logic [7:0] wbuf [8];

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    // Monitor: pops expected items as ack decisions and send bytes appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (ack_valid) begin
                if (q.size() == 0) check(0, "R1 unexpected ack", ack, 0);
                else begin
                    exp_t e;
                    e = q.pop_front();
                    check(!e.is_tx && ack == e.val[0], e.tag, ack, e.val[0]);
                end
            end
            if (tx_valid && !tx_prev) begin
                if (q.size() == 0) check(0, "R12 unexpected tx", tx_data, 0);
                else begin
                    exp_t e;
                    e = q.pop_front();
                    check(e.is_tx && tx_data == e.val, e.tag, tx_data, e.val);
                end
            end
            tx_prev <= tx_valid;
        end
    end

    task automatic do_start();
        @(negedge clk) ev_start = 1'b1;
        @(negedge clk) ev_start = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk) ev_stop = 1'b1;
        @(negedge clk) ev_stop = 1'b0;
        @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b, input bit exp_ack, input string tag);
        exp_t e;
        e.is_tx = 1'b0; e.val = {7'd0, exp_ack}; e.tag = tag;
        q.push_back(e);
        @(negedge clk) begin rx_byte = b; rx_valid = 1'b1; end
        @(negedge clk) rx_valid = 1'b0;
    endtask

    task automatic recv(input bit give_ack, input logic [7:0] expv, input string tag);
        exp_t e;
        e.is_tx = 1'b1; e.val = expv; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        while (!tx_valid) @(negedge clk);
        mack = give_ack; mack_valid = 1'b1;
        @(negedge clk) mack_valid = 1'b0;
    endtask

    task automatic do_write(input logic [15:0] a16, input int n);
        int a;
        bit lk;
        a = a16 & 16'h1FFF;
        do_start();
        send({4'b1010, DEV, 1'b0}, 1, "R1 write header");
        send(a16[15:8], 1, "R2 addr hi");
        send(a16[7:0], 1, "R2 addr lo");
        lk = wp && a >= 'h1800;
        for (int i = 0; i < n; i++) begin
            if (lk) begin
                send(wbuf[i], 0, "R8 protected byte refused");
                break;
            end
            send(wbuf[i], 1, "R3 data byte");
            ref_mem[a] = wbuf[i];
            a = (a & 'h1FE0) | ((a + 1) & 'h1F);
        end
        ref_ptr = a;
        do_stop();
    endtask

    task automatic rd_bytes(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            recv(i < n - 1, ref_mem[ref_ptr], tag);
            ref_ptr = (ref_ptr + 1) & 'h1FFF;
        end
    endtask

    task automatic do_rand_read(input logic [15:0] a16, input int n, input string tag);
        do_start();
        send({4'b1010, DEV, 1'b0}, 1, "R6 dummy write header");
        send(a16[15:8], 1, "R6 addr hi");
        send(a16[7:0], 1, "R6 addr lo");
        do_start();
        send({4'b1010, DEV, 1'b1}, 1, "R6 read header");
        ref_ptr = a16 & 16'h1FFF;
        rd_bytes(n, tag);
        do_stop();
    endtask

    task automatic do_cur_read(input int n, input string tag);
        do_start();
        send({4'b1010, DEV, 1'b1}, 1, "R5 read header");
        rd_bytes(n, tag);
        do_stop();
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 8192; i++) begin
            arr[i]     = 8'(i ^ (i >> 5));
            ref_mem[i] = 8'(i ^ (i >> 5));
        end
        repeat (3) @(negedge clk);
        check(ack_valid == 0, "R1 reset ack_valid", ack_valid, 0);
        check(tx_valid == 0 && mem_rd_en == 0, "R12 reset read idle", tx_valid, 0);
        check(pb_wr_en == 0 && pb_commit == 0, "R3 reset no write", pb_wr_en, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Byte write, then random read of it
        wbuf[0] = 8'h5A;
        do_write(16'h0123, 1);
        do_rand_read(16'h0123, 1, "R6 random read byte");
        // Current address read: last accessed + 1
        do_cur_read(2, "R5 current address read");

        // Page write that wraps within the page
        wbuf[0] = 8'hC1; wbuf[1] = 8'hC2; wbuf[2] = 8'hC3; wbuf[3] = 8'hC4;
        do_write(16'h003E, 4);
        do_rand_read(16'h0020, 2, "R4 page wrap low bytes");
        do_rand_read(16'h003E, 2, "R4 page wrap top bytes");
        do_rand_read(16'h0040, 1, "R4 next page untouched");

        // Upper address bits ignored
        wbuf[0] = 8'h77;
        do_write(16'hE1AB, 1);
        do_rand_read(16'h01AB, 1, "R2 upper address bits ignored");

        // Sequential read across the top of the array
        do_rand_read(16'h1FFE, 4, "R7 sequential wrap");
        do_cur_read(1, "R7 pointer after wrap");

        // Protection
        wp = 1'b1;
        wbuf[0] = 8'hEE; wbuf[1] = 8'hEF;
        do_write(16'h1850, 2);
        check(stg_a.size() == 0, "R8 no page buffer write", stg_a.size(), 0);
        do_rand_read(16'h1850, 1, "R8 protected byte unchanged");
        wbuf[0] = 8'h31;
        do_write(16'h0400, 1);
        do_rand_read(16'h0400, 1, "R9 low region writable with wp");
        wp = 1'b0;
        wbuf[0] = 8'h92;
        do_write(16'h1900, 1);
        do_rand_read(16'h1900, 1, "R9 top region writable without wp");

        // Wrong device select
        do_start();
        send({4'b1010, 3'b011, 1'b0}, 0, "R1 mismatched header");
        @(negedge clk) begin rx_byte = 8'h12; rx_valid = 1'b1; end
        @(negedge clk) rx_valid = 1'b0;
        check(ack_valid == 0, "R1 ignored after mismatch", ack_valid, 0);
        do_stop();

        // STOP after one address byte: pointer unchanged
        do_cur_read(1, "R5 current read before abort");
        do_start();
        send({4'b1010, DEV, 1'b0}, 1, "R10 header");
        send(8'h07, 1, "R10 addr hi only");
        do_stop();
        check(stg_a.size() == 0, "R10 no write staged", stg_a.size(), 0);
        do_cur_read(1, "R10 pointer kept");

        // Bytes after a refused read are ignored until STOP
        do_start();
        send({4'b1010, DEV, 1'b1}, 1, "R11 read header");
        rd_bytes(1, "R11 read byte");
        @(negedge clk) begin rx_byte = 8'h44; rx_valid = 1'b1; end
        @(negedge clk) rx_valid = 1'b0;
        check(ack_valid == 0, "R11 no ack while waiting for stop", ack_valid, 0);
        do_stop();
        do_cur_read(1, "R11 pointer after ignored byte");

        repeat (5) @(negedge clk);
        check(q.size() == 0, "R12 all expected items seen", q.size(), 0);
        finish_run();
    end

endmodule